// File: doc/BRIEF.md
# Serial Port Register and Command Controller

This block is the register face of a simple asynchronous serial port. A host reaches it through a 64-byte window on a plain strobe bus: a 6-bit address, separate write and read strobes, and 8-bit data. The block holds two mode registers reached through one offset behind an auto-advancing pointer, a packed command register, a status view, an interrupt status view and an interrupt mask. Its one level-sensitive interrupt line is high while any unmasked interrupt source is active.

Outgoing bytes are held in a one-byte buffer. They are offered to a downstream serializer through a valid/accept handshake, but only while the transmitter is enabled. Incoming bytes from a deserializer enter a small receive queue through a valid/ready handshake while the receiver is enabled. A line-break indication places a zero byte in the queue and raises a break-change interrupt. A read of the data offset pops the oldest byte. Read data is combinational and is valid in the same cycle as the read strobe. All state changes happen at the clock edge that ends the access.

Top module: `uart_regctl`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x08. The transmitter and receiver are disabled, so `tx_valid` and `rx_ready` are low, and `irq` is low.
- R2: At offset 0x00 the first access after reset reaches mode register 1. Every later access reaches mode register 2. Command code 1 in bits [6:4] sends the pointer back to mode register 1.
- R3: Status bits: bit0 = queue not empty, bit1 = queue full, bit2 = transmitter enabled, bit3 = transmit buffer empty. Bits [7:4] read 0.
- R4: Interrupt status at offset 0x14 (read): bit0 = status bit2. bit1 = status bit1 when mode register 1 bit6 is set, otherwise status bit0. bit2 = break-change flag. All other bits read 0.
- R5: A write to offset 0x14 loads the mask. `irq` is high exactly when interrupt status AND mask is nonzero, and it takes the new value one cycle after the causing write.
- R6: A command write is a write to offset 0x08. Command bits [3:2] control the transmitter and bits [1:0] control the receiver. Value 1 enables, 2 disables, and 0 or 3 leaves the state unchanged.
- R7: Command bits [6:4]: 2 disables the receiver and empties the queue. 3 disables the transmitter, drops the buffered byte and marks the buffer empty. 5 clears the break-change flag. 4, 6 and 7 do nothing. The [6:4] action is applied before the enable fields of the same write.
- R8: A write to offset 0x0C fills the transmit buffer and clears the empty flag. `tx_valid` is high while the transmitter is enabled and the buffer is not empty, with `tx_data` holding the byte. A cycle with both `tx_valid` and `tx_accept` high marks the buffer empty.
- R9: `rx_ready` is high while the receiver is enabled and the queue is not full. Bytes taken on `rx_valid && rx_ready` are read back at offset 0x0C oldest first, and each read pops one byte. A read of an empty queue returns 0.
- R10: A pulse on `rx_break` sets the break-change flag and queues a zero byte. When the queue is full, the zero overwrites the newest byte.
- R11: Reads of offsets other than 0x00, 0x04, 0x0C and 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_accept | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can take a byte |
| rx_break | input | 1 | Line break detected (one-cycle pulse) |

## Verification
A wrong enable or empty flag shows up on `tx_valid` and `rx_ready` at the next sampling point after the command, and on status bits 2, 3 and 0 at the next read. A wrong queue count or a wrong shift shows up as out-of-order or missing bytes on the first pops after the fault. A slip in the mode pointer appears as the wrong register on the second access to offset 0x00. A wrong interrupt-source choice or break flag reaches `irq` one cycle after the mask write that exposes it.

// File: rtl/uart_regctl.sv
module uart_regctl #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_accept,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          rx_break
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] A_MODE = AW'(6'h00);
  localparam logic [AW-1:0] A_STAT = AW'(6'h04);
  localparam logic [AW-1:0] A_CMD  = AW'(6'h08);
  localparam logic [AW-1:0] A_DATA = AW'(6'h0C);
  localparam logic [AW-1:0] A_INT  = AW'(6'h14);

  logic [DW-1:0] mode1_q, mode2_q, imr_q, tbuf_q;
  logic          ptr_q, ptr_n;
  logic          tx_en_q, tx_en_n, rx_en_q, rx_en_n;
  logic          tempty_q, tempty_n, brk_q, brk_n, rx_clr;
  logic [DW-1:0] fifo_q [DEPTH];
  logic [DW-1:0] fifo_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n, cnt_mid;

  wire mode_acc = (bus_wr || bus_rd) && bus_addr == A_MODE;
  wire cmd_wr   = bus_wr && bus_addr == A_CMD;
  wire tbuf_wr  = bus_wr && bus_addr == A_DATA;
  wire pop      = bus_rd && bus_addr == A_DATA && cnt_q != '0;
  wire push     = rx_valid && rx_ready;

  wire st_rdy   = cnt_q != '0;
  wire st_full  = cnt_q == FULL_C;
  wire [DW-1:0] status = DW'({tempty_q, tx_en_q, st_full, st_rdy});
  wire          rx_int = mode1_q[6] ? st_full : st_rdy;
  wire [DW-1:0] isr    = DW'({brk_q, rx_int, tx_en_q});

  assign tx_valid = tx_en_q && !tempty_q;
  assign tx_data  = tbuf_q;
  assign rx_ready = rx_en_q && !st_full;
  assign irq      = |(isr & imr_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_MODE:  bus_rdata = ptr_q ? mode2_q : mode1_q;
        A_STAT:  bus_rdata = status;
        A_DATA:  bus_rdata = st_rdy ? fifo_q[0] : '0;
        A_INT:   bus_rdata = isr;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    ptr_n    = ptr_q;
    tx_en_n  = tx_en_q;
    rx_en_n  = rx_en_q;
    tempty_n = tempty_q;
    brk_n    = brk_q;
    rx_clr   = 1'b0;
    if (tx_valid && tx_accept) tempty_n = 1'b1;
    if (mode_acc) ptr_n = 1'b1;
    if (cmd_wr) begin
      case (bus_wdata[6:4])
        3'd1: ptr_n = 1'b0;
        3'd2: begin rx_en_n = 1'b0; rx_clr = 1'b1; end
        3'd3: begin tx_en_n = 1'b0; tempty_n = 1'b1; end
        3'd5: brk_n = 1'b0;
        default: ;
      endcase
      case (bus_wdata[3:2])
        2'd1: tx_en_n = 1'b1;
        2'd2: tx_en_n = 1'b0;
        default: ;
      endcase
      case (bus_wdata[1:0])
        2'd1: rx_en_n = 1'b1;
        2'd2: rx_en_n = 1'b0;
        default: ;
      endcase
    end
    if (tbuf_wr) tempty_n = 1'b0;
    if (rx_break) brk_n = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) fifo_n[i] = fifo_q[i];
    cnt_mid = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) fifo_n[i] = fifo_q[i + 1];
      cnt_mid = cnt_q - 1'b1;
    end
    cnt_n = cnt_mid;
    if (rx_break) begin
      if (cnt_mid == FULL_C) fifo_n[DEPTH-1] = '0;
      else begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_mid) fifo_n[i] = '0;
        cnt_n = cnt_mid + 1'b1;
      end
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_mid) fifo_n[i] = rx_data;
      cnt_n = cnt_mid + 1'b1;
    end
    if (rx_clr) cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1_q  <= '0;
      mode2_q  <= '0;
      imr_q    <= '0;
      tbuf_q   <= '0;
      ptr_q    <= 1'b0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tempty_q <= 1'b1;
      brk_q    <= 1'b0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) begin
        if (ptr_q) mode2_q <= bus_wdata;
        else       mode1_q <= bus_wdata;
      end
      if (bus_wr && bus_addr == A_INT) imr_q <= bus_wdata;
      if (tbuf_wr) tbuf_q <= bus_wdata;
      ptr_q    <= ptr_n;
      tx_en_q  <= tx_en_n;
      rx_en_q  <= rx_en_n;
      tempty_q <= tempty_n;
      brk_q    <= brk_n;
      cnt_q    <= cnt_n;
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= fifo_n[i];
    end
  end
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_accept,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_break,
  input logic [CW-1:0] cnt,
  input logic          brk
);
  wire wr_cmd  = bus_wr && bus_addr == AW'(6'h08);
  wire wr_data = bus_wr && bus_addr == AW'(6'h0C);
  wire rd_data = bus_rd && bus_addr == AW'(6'h0C);

  AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_accept && !wr_data |=> !tx_valid);  // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_accept && !wr_data && !wr_cmd |=> tx_valid && $stable(tx_data));  // R8
  AST_RX_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !rd_data && !rx_break && !wr_cmd |=> cnt == $past(cnt) + 1'b1);  // R9
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));  // R9
  AST_TX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] != 2'd1 |=> !tx_valid);  // R7
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(6'h14) && bus_wdata == '0 |=> !irq);  // R5
  AST_BREAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> brk);  // R10
endmodule

bind uart_regctl uart_regctl_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_accept(tx_accept), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_break(rx_break), .cnt(cnt_q), .brk(brk_q)
);

// File: tb/sim_uart_regctl.sv
module sim_uart_regctl;
  localparam int PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq, tx_valid, tx_accept = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_regctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_accept(tx_accept), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_break(rx_break)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 6'h04, 8'h08);
    check("R1 irq", 8'(irq), 8'h00);
    check("R1 tx_valid", 8'(tx_valid), 8'h00);
    check("R1 rx_ready", 8'(rx_ready), 8'h00);
    rd_chk("R4 isr idle", 6'h14, 8'h00);
  endtask

  task automatic t_mode_ptr;
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    wr(6'h00, 8'h33);
    wr(6'h08, 8'h10);
    rd_chk("R2 first mode1", 6'h00, 8'h11);
    rd_chk("R2 then mode2", 6'h00, 8'h33);
    rd_chk("R2 stays mode2", 6'h00, 8'h33);
  endtask

  task automatic t_tx;
    wr(6'h08, 8'h04);
    rd_chk("R3 tx enabled", 6'h04, 8'h0C);
    rd_chk("R4 tx int", 6'h14, 8'h01);
    wr(6'h14, 8'h01);
    check("R5 irq on", 8'(irq), 8'h01);
    wr(6'h0C, 8'hA5);
    check("R8 valid", 8'(tx_valid), 8'h01);
    check("R8 data", tx_data, 8'hA5);
    rd_chk("R3 not empty", 6'h04, 8'h04);
    @(negedge clk); tx_accept = 1'b1;
    @(negedge clk); tx_accept = 1'b0;
    check("R8 taken", 8'(tx_valid), 8'h00);
    rd_chk("R8 empty again", 6'h04, 8'h0C);
    wr(6'h08, 8'h08);
    rd_chk("R6 tx disable", 6'h04, 8'h08);
    check("R5 irq off", 8'(irq), 8'h00);
    wr(6'h08, 8'h0C);
    rd_chk("R6 reserved ignored", 6'h04, 8'h08);
    wr(6'h0C, 8'h5A);
    check("R8 held while disabled", 8'(tx_valid), 8'h00);
    rd_chk("R8 buffer full", 6'h04, 8'h00);
    wr(6'h08, 8'h30);
    rd_chk("R7 tx reset", 6'h04, 8'h08);
    wr(6'h08, 8'h04);
    check("R7 byte dropped", 8'(tx_valid), 8'h00);
  endtask

  task automatic t_rx;
    wr(6'h08, 8'h01);
    check("R9 ready", 8'(rx_ready), 8'h01);
    push(8'h10); push(8'h20); push(8'h30);
    rd_chk("R3 rx ready", 6'h04, 8'h0D);
    rd_chk("R4 rx int on ready", 6'h14, 8'h03);
    push(8'h40);
    check("R9 full not ready", 8'(rx_ready), 8'h00);
    rd_chk("R3 full", 6'h04, 8'h0F);
    push(8'h50);
    rd_chk("R9 order 0", 6'h0C, 8'h10);
    rd_chk("R9 order 1", 6'h0C, 8'h20);
    rd_chk("R9 order 2", 6'h0C, 8'h30);
    rd_chk("R9 order 3", 6'h0C, 8'h40);
    rd_chk("R9 empty read", 6'h0C, 8'h00);
    rd_chk("R3 drained", 6'h04, 8'h0C);
  endtask

  task automatic t_full_mode;
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    push(8'h61);
    rd_chk("R4 full-mode one byte", 6'h14, 8'h01);
    push(8'h62); push(8'h63); push(8'h64);
    rd_chk("R4 full-mode full", 6'h14, 8'h03);
    wr(6'h14, 8'h02);
    check("R5 rx irq", 8'(irq), 8'h01);
    wr(6'h14, 8'h00);
    check("R5 masked", 8'(irq), 8'h00);
  endtask

  task automatic t_break;
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd_chk("R10 flag", 6'h14, 8'h07);
    rd_chk("R10 byte 0", 6'h0C, 8'h61);
    rd_chk("R10 byte 1", 6'h0C, 8'h62);
    rd_chk("R10 byte 2", 6'h0C, 8'h63);
    rd_chk("R10 overwrite", 6'h0C, 8'h00);
    wr(6'h14, 8'h04);
    check("R5 break irq", 8'(irq), 8'h01);
    wr(6'h08, 8'h50);
    rd_chk("R7 break clear", 6'h14, 8'h01);
    check("R7 break irq low", 8'(irq), 8'h00);
    wr(6'h08, 8'h40);
    rd_chk("R7 code 4 no effect", 6'h04, 8'h0C);
  endtask

  task automatic t_rx_reset;
    push(8'h71); push(8'h72);
    rd_chk("R9 two queued", 6'h04, 8'h0D);
    wr(6'h08, 8'h20);
    rd_chk("R7 rx reset", 6'h04, 8'h0C);
    check("R7 rx disabled", 8'(rx_ready), 8'h00);
    wr(6'h0C, 8'h99);
    wr(6'h08, 8'h35);
    rd_chk("R7 order tx", 6'h04, 8'h0C);
    check("R7 order tx idle", 8'(tx_valid), 8'h00);
    check("R7 order rx", 8'(rx_ready), 8'h01);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 0x3C", 6'h3C, 8'h00);
    rd_chk("R11 0x08", 6'h08, 8'h00);
    rd_chk("R11 0x10", 6'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_mode_ptr;
    t_tx;
    t_rx;
    t_full_mode;
    t_break;
    t_rx_reset;
    t_unmapped;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule